// File: doc/BRIEF.md
# Smart card warm reset generator

This block produces the warm reset pulse for a smart card interface. Software programs a reset-low duration, counted in card clock cycles, into two byte-wide count registers. It then sets an arm bit. On the rising edge of that bit the card reset line drops to 0. It stays at 0 for the programmed number of card clocks and then returns to 1.

A busy flag is high for the whole low phase, so software can poll it. The count is taken at the moment the pulse starts. Later writes to the count registers prepare the next pulse and do not change the current one. The register bus is synchronous to the card clock, which is also the block's only clock.

The power-on count is 400. This meets the minimum reset-low time of the card standard without any programming. Typical warm-reset settings lie between 40000 and 45000 card clocks.

Top module: `wrst_gen`

## Requirements
- R1: While and after reset, `card_rst_o` is 1 and `busy_o` is 0. The count register holds 400, so arming with no count write gives a 400-cycle low pulse.
- R2: Register map, with writes taking effect at the clock edge where `wr_en_i` is 1: address 0 is the low count byte, address 1 is the high count byte, and address 2 is control. Bit 0 of the control register is the arm bit.
- R3: A write that changes the arm bit from 0 to 1 while idle starts a pulse. `card_rst_o` is 0 and `busy_o` is 1 from the cycle after that write edge.
- R4: `card_rst_o` stays 0 for exactly N card clock cycles, where N is the 16-bit count, and then returns to 1. `busy_o` is 1 in exactly those cycles.
- R5: Writing 1 to the arm bit when it is already 1 starts no pulse.
- R6: A count of 0 gives a low pulse of exactly 1 cycle.
- R7: The count is captured when the pulse starts. Count writes during a pulse leave its length unchanged.
- R8: Clearing the arm bit during a pulse does not shorten the pulse. A new 0-to-1 arm edge during a pulse is ignored.
- R9: When idle, `card_rst_o` stays at 1 unless a new arm edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock; the counting time base and the register bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| card_rst_o | output | 1 | Card reset line level |
| busy_o | output | 1 | High while the reset-low phase runs |

## Verification
The bench builds the block with its default parameters: a 16-bit count in two 8-bit bytes and a power-on count of 400. The 16-bit width lets one directed test run a realistic 40000-cycle warm reset within the cycle budget. Short counts such as 255, 256 and 257 exercise the carry from the low byte into the high byte. Writes issued in the middle of a pulse are accounted for cycle by cycle, so the measured low length can be compared with the captured count exactly.

// File: rtl/wrst_pkg.sv
`timescale 1ns/1ps
package wrst_pkg;
  localparam int unsigned CTRL_ARM_BIT = 0;

  function automatic int unsigned num_bytes(input int unsigned cnt_w, input int unsigned data_w);
    return (cnt_w + data_w - 1) / data_w;
  endfunction
endpackage

// File: rtl/wrst_regs.sv
`timescale 1ns/1ps
module wrst_regs
  import wrst_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned RESET_CNT = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              arm_rise_o
);
  localparam int unsigned NB = num_bytes(CNT_W, DATA_W);
  localparam int unsigned CTRL_ADDR = NB;
  localparam logic [NB*DATA_W-1:0] RST_VAL = (NB*DATA_W)'(RESET_CNT);

  logic [DATA_W-1:0] byte_q [NB];
  logic [NB*DATA_W-1:0] cnt_flat;
  logic arm_q;
  logic ctrl_wr;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q[g] <= RST_VAL[g*DATA_W +: DATA_W];
      else if (wr_en_i && (wr_addr_i == ADDR_W'(g))) byte_q[g] <= wr_data_i;
    end
    assign cnt_flat[g*DATA_W +: DATA_W] = byte_q[g];
  end

  assign cnt_o   = cnt_flat[CNT_W-1:0];
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else if (ctrl_wr) arm_q <= wr_data_i[CTRL_ARM_BIT];
  end

  // start request lands on the same edge that writes the arm bit
  assign arm_rise_o = ctrl_wr && wr_data_i[CTRL_ARM_BIT] && !arm_q;
endmodule

// File: rtl/wrst_timer.sv
`timescale 1ns/1ps
module wrst_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             active_o,
  output logic [CNT_W-1:0] remain_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        remain_q <= (load_i == '0) ? ONE : load_i;
      end
    end else if (remain_q == ONE) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else begin
      remain_q <= remain_q - ONE;
    end
  end

  assign active_o = active_q;
  assign remain_o = remain_q;
endmodule

// File: rtl/wrst_gen.sv
`timescale 1ns/1ps
module wrst_gen #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned RESET_CNT = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              card_rst_o,
  output logic              busy_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] remain;
  logic             arm_rise;
  logic             active;

  wrst_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_CNT(RESET_CNT)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cnt_o(cnt), .arm_rise_o(arm_rise)
  );

  wrst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i(arm_rise), .load_i(cnt),
    .active_o(active), .remain_o(remain)
  );

  assign card_rst_o = ~active;
  assign busy_o     = active;
endmodule

// File: rtl/wrst_gen_chk.sv
`timescale 1ns/1ps
module wrst_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             card_rst_i,
  input logic [CNT_W-1:0] remain_i,
  input logic [CNT_W-1:0] cnt_i
);
  logic [CNT_W:0] lo_cnt;
  logic [CNT_W:0] exp_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      exp_len <= '0;
    end else if (start_i && !busy_i) begin
      lo_cnt  <= '0;
      exp_len <= (cnt_i == '0) ? (CNT_W+1)'(1) : {1'b0, cnt_i};
    end else if (busy_i) begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> busy_i && !card_rst_i);

  p_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> lo_cnt == exp_len);

  p_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> remain_i != '0);

  p_no_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && remain_i > (CNT_W)'(1) |=> busy_i && remain_i == $past(remain_i) - 1'b1);

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !start_i |=> !busy_i && card_rst_i);
endmodule

bind wrst_gen wrst_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(arm_rise), .busy_i(busy_o),
  .card_rst_i(card_rst_o), .remain_i(remain), .cnt_i(cnt)
);

// File: tb/wrst_gen_tb.sv
`timescale 1ns/1ps
module wrst_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       card_rst_o;
  logic       busy_o;

  int n_chk = 0;
  int n_fail = 0;
  int busy_bad = 0;

  always #2.5 clk_i = ~clk_i;

  wrst_gen u_dut (.*);

  localparam int NV = 8;
  localparam int unsigned V_CNT [NV] = '{1, 2, 3, 0, 255, 256, 257, 1000};
  localparam int unsigned V_EXP [NV] = '{1, 2, 3, 1, 255, 256, 257, 1000};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load(input int unsigned c);
    wr(2'd0, c[7:0]);
    wr(2'd1, c[15:8]);
  endtask

  task automatic fire();
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (card_rst_o == 1'b0 && n < 100000) begin
      if (busy_o !== 1'b1) busy_bad++;
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic idle_high(input string req, input int cycles);
    int hi = 0;
    for (int i = 0; i < cycles; i++) begin
      if (card_rst_o === 1'b1 && busy_o === 1'b0) hi++;
      @(negedge clk_i);
    end
    check(req, hi, cycles);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    check("R1 reset card_rst", int'(card_rst_o), 1);
    check("R1 reset busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_high("R9 idle after reset", 4);

    // R1: default count of 400, armed with no count write
    wr(2'd2, 8'h01);
    check("R3 low right after arm", int'(card_rst_o), 0);
    measure(n);
    check("R1 default length", n, 400);

    // R5: arm already set, writing 1 again does nothing
    wr(2'd2, 8'h01);
    idle_high("R5 rewrite arm no pulse", 6);

    // vector table: R2 byte map, R4 length, R6 zero
    for (int v = 0; v < NV; v++) begin
      load(V_CNT[v]);
      fire();
      measure(n);
      check($sformatf("R4 vec %0d length (R2 R6)", v), n, int'(V_EXP[v]));
      check("R4 released high", int'(card_rst_o), 1);
      idle_high("R9 idle after pulse", 2);
    end
    check("R4 busy matched low phase", busy_bad, 0);

    // R7: count writes during a pulse do not change it
    load(30);
    fire();
    load(5);
    measure(n);
    check("R7 captured count", n + 2, 30);
    fire();
    measure(n);
    check("R7 new count used next", n, 5);

    // R8: clearing arm mid-pulse does not abort
    load(20);
    fire();
    wr(2'd2, 8'h00);
    measure(n);
    check("R8 clear arm no abort", n + 1, 20);

    // R8: re-arm edge during pulse ignored
    load(10);
    fire();
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    measure(n);
    check("R8 re-arm ignored", n + 2, 10);
    idle_high("R8 no retrigger after pulse", 5);

    // realistic warm reset length
    load(40000);
    fire();
    measure(n);
    check("R4 long pulse", n, 40000);
    check("R4 busy long pulse", busy_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule